// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block decides whether a received frame's multicast destination address should be accepted. It keeps a 4096-bit hash table, stored as 128 words of 32 bits. Each 48-bit MAC address is reduced to a 12-bit vector taken from a window over its two most significant bytes. The vector's upper 7 bits pick a table word and its lower 5 bits pick a bit inside that word.

Software rebuilds the table through a configuration port, one update at a time. An update opens with a begin strobe, which carries an optional clear and the hash window to use. Add strobes follow, each setting one table bit. A commit strobe closes the update. The filter turns itself on, with the chosen window, only when the update added at least one address.

The receive path presents addresses on a lookup port. One cycle later it gets a registered hit or miss flag, with a valid flag beside it.

Top module: `mcast_hash_filter`

## Requirements
- R1: The 12-bit vector is a window of the address `a[47:0]`. Byte k of the address sits in bits 8k+7:8k. Window 0 takes `a[47:36]`, window 1 takes `a[46:35]`, window 2 takes `a[45:34]` and window 3 takes `a[43:32]`. Vector bit 0 is the lowest address bit of the window.
- R2: Vector bits 11:5 select one of the 128 table words and vector bits 4:0 select the bit inside it. An added address hits. An address that maps to a different, unset vector misses.
- R3: An add only sets its own bit. Bits set earlier stay set, and no single bit is ever cleared.
- R4: A begin strobe with `cfgClear=1` zeroes the entire table. A begin strobe with `cfgClear=0` leaves the table untouched.
- R5: A begin strobe resets the entry counter to zero and records `cfgMode` as the pending window. Every add increments the counter. A commit taken while the counter is non-zero turns the filter on and makes the pending window the active window used by lookups.
- R6: A commit taken while the counter is zero changes neither the enable state nor the active window. Once on, the filter stays on until reset.
- R7: `rspHit` is 1 only if all three hold: the filter is on, the lookup address has group bit `a[0]=1`, and the table bit indexed through the active window is set. Adds are hashed with the pending window.
- R8: The result appears exactly one cycle after `lkValid`. `rspValid` follows `lkValid` with that one-cycle delay, and `rspHit` is 0 in any cycle where `rspValid` is 0.
- R9: A lookup sees the table, the enable state and the active window as they stood before its own clock edge. An add or commit in the same cycle as a lookup becomes visible to lookups from the following cycle.
- R10: After reset the table is empty, the filter is off and the active window is 0, so every lookup misses.
- R11: An add in the same cycle as a begin strobe is applied after that begin's clear. It is hashed with that cycle's `cfgMode` and counts as the first entry of the new update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBegin | input | 1 | Starts an update: resets the counter and latches the window |
| cfgClear | input | 1 | With cfgBegin, zeroes the table |
| cfgMode | input | 2 | Hash window selected at begin |
| cfgAdd | input | 1 | Adds cfgAddr to the table |
| cfgAddr | input | 48 | Address to add |
| cfgCommit | input | 1 | Ends the update; enables the filter if the counter is non-zero |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 48 | Destination address to look up |
| rspValid | output | 1 | Lookup result valid, one cycle after lkValid |
| rspHit | output | 1 | Lookup hit |

## Verification
The two functions that can fall in the same cycle are a configuration change and a lookup. The change can be an add, a commit or a begin-with-clear, and the lookup may index the very bit that the change alters.

Directed steps provoke this case. One step adds an address and looks it up in the same cycle, and the next step repeats the lookup. Another step commits and looks up together. Random traffic also mixes all the strobes with lookups.

A bench model judges every response from the state the model held before that cycle's edge. The first lookup must report the old answer, and the following cycle must show the new one.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int ADDR_W    = 48;
  localparam int TBL_WORDS = 128;
  localparam int WORD_W    = 32;
  localparam int WIDX_W    = $clog2(TBL_WORDS);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int VEC_W     = WIDX_W + BIT_W;
  localparam int HI_W      = 16;          // two top address bytes feed the window
  localparam int MODE_W    = 2;

  // strobes from control to the table datapath
  typedef struct packed {
    logic             clrAll;
    logic             setBit;
    logic [VEC_W-1:0] setVec;
  } tblCtl_t;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
  import mhf_pkg::*;
(
  input  logic [HI_W-1:0]   hiBytes,   // address bits 47:32
  input  logic [MODE_W-1:0] mode,
  output logic [VEC_W-1:0]  vec
);
  // window start offset inside the top two bytes
  function automatic int unsigned winOffset(input logic [MODE_W-1:0] m);
    case (m)
      2'd0:    winOffset = 4;
      2'd1:    winOffset = 3;
      2'd2:    winOffset = 2;
      default: winOffset = 0;
    endcase
  endfunction

  always_comb begin
    vec = hiBytes[winOffset(mode) +: VEC_W];
  end
endmodule

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBegin,
  input  logic              cfgClear,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgAdd,
  input  logic [HI_W-1:0]   cfgHi,
  input  logic              cfgCommit,
  output tblCtl_t           tblCtl,
  output logic              filtEn,
  output logic [MODE_W-1:0] actMode
);
  logic [CNT_W-1:0]  useCnt;
  logic [MODE_W-1:0] pendMode;
  logic [MODE_W-1:0] addMode;
  logic [VEC_W-1:0]  addVec;

  // an add in the begin cycle hashes with the new window (R11)
  assign addMode = cfgBegin ? cfgMode : pendMode;

  mhf_hash u_addHash (
    .hiBytes (cfgHi),
    .mode    (addMode),
    .vec     (addVec)
  );

  always_comb begin
    tblCtl.clrAll = cfgBegin & cfgClear;
    tblCtl.setBit = cfgAdd;
    tblCtl.setVec = addVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      useCnt   <= '0;
      pendMode <= '0;
      filtEn   <= 1'b0;
      actMode  <= '0;
    end else begin
      if (cfgBegin) begin
        pendMode <= cfgMode;
        useCnt   <= cfgAdd ? CNT_W'(1) : '0;
      end else if (cfgAdd && (useCnt != '1)) begin
        useCnt <= useCnt + CNT_W'(1);
      end
      if (cfgCommit && (useCnt != '0)) begin
        filtEn  <= 1'b1;
        actMode <= pendMode;
      end
    end
  end

  AST_EMPTY_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCommit && useCnt == '0) |=> ($stable(filtEn) && $stable(actMode))); // R6
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    filtEn |=> filtEn); // R6
  AST_BEGIN_RESETS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBegin && !cfgAdd) |=> (useCnt == '0)); // R5
endmodule

// File: rtl/mhf_table.sv
module mhf_table
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tblCtl_t           tblCtl,
  input  logic              filtEn,
  input  logic [MODE_W-1:0] actMode,
  input  logic              lkValid,
  input  logic [HI_W-1:0]   lkHi,
  input  logic              lkGroup,
  output logic              rspValid,
  output logic              rspHit
);
  logic [WORD_W-1:0] tblWord [TBL_WORDS];
  logic [VEC_W-1:0]  lkVec;
  logic [WIDX_W-1:0] setIdx;
  logic [BIT_W-1:0]  setPos;
  logic [WORD_W-1:0] setMask;
  logic              lkBit;

  assign setIdx  = tblCtl.setVec[VEC_W-1:BIT_W];
  assign setPos  = tblCtl.setVec[BIT_W-1:0];
  assign setMask = WORD_W'(1) << setPos;

  mhf_hash u_lkHash (
    .hiBytes (lkHi),
    .mode    (actMode),
    .vec     (lkVec)
  );

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_word
    logic hitWord;
    assign hitWord = tblCtl.setBit && (setIdx == WIDX_W'(w));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblWord[w] <= '0;
      end else if (tblCtl.clrAll) begin
        tblWord[w] <= hitWord ? setMask : '0;
      end else if (hitWord) begin
        tblWord[w] <= tblWord[w] | setMask;
      end
    end
  end

  assign lkBit = tblWord[lkVec[VEC_W-1:BIT_W]][lkVec[BIT_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= lkValid & filtEn & lkGroup & lkBit;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid); // R8
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!rspValid && !rspHit)); // R8
  AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !filtEn |=> !rspHit); // R7
  AST_GROUP_BIT_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkGroup) |=> !rspHit); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (tblCtl.clrAll && !tblCtl.setBit) |=> (tblWord[0] == '0 && tblWord[TBL_WORDS-1] == '0)); // R4
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBegin,
  input  logic              cfgClear,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgAdd,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgCommit,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              rspValid,
  output logic              rspHit
);
  tblCtl_t           tblCtl;
  logic              filtEn;
  logic [MODE_W-1:0] actMode;
  logic              unusedLowBits;

  // only the top two bytes and the group bit matter
  assign unusedLowBits = ^{cfgAddr[ADDR_W-HI_W-1:0], lkAddr[ADDR_W-HI_W-1:1]};

  mhf_ctrl #(.CNT_W(8)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgBegin  (cfgBegin),
    .cfgClear  (cfgClear),
    .cfgMode   (cfgMode),
    .cfgAdd    (cfgAdd),
    .cfgHi     (cfgAddr[ADDR_W-1 -: HI_W]),
    .cfgCommit (cfgCommit),
    .tblCtl    (tblCtl),
    .filtEn    (filtEn),
    .actMode   (actMode)
  );

  mhf_table u_table (
    .clk      (clk),
    .rstN     (rstN),
    .tblCtl   (tblCtl),
    .filtEn   (filtEn),
    .actMode  (actMode),
    .lkValid  (lkValid),
    .lkHi     (lkAddr[ADDR_W-1 -: HI_W]),
    .lkGroup  (lkAddr[0]),
    .rspValid (rspValid),
    .rspHit   (rspHit)
  );
endmodule

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgBegin, cfgClear, cfgAdd, cfgCommit, lkValid;
  logic [1:0]  cfgMode;
  logic [47:0] cfgAddr, lkAddr;
  logic        rspValid, rspHit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // bench model
  logic [4095:0] mTbl;
  logic          mEn;
  logic [1:0]    mAct, mPend;
  int            mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_hash_filter u_dut (
    .clk(clk), .rstN(rstN), .cfgBegin(cfgBegin), .cfgClear(cfgClear),
    .cfgMode(cfgMode), .cfgAdd(cfgAdd), .cfgAddr(cfgAddr),
    .cfgCommit(cfgCommit), .lkValid(lkValid), .lkAddr(lkAddr),
    .rspValid(rspValid), .rspHit(rspHit)
  );

  function automatic logic [11:0] hashVec(input logic [47:0] a, input logic [1:0] m);
    case (m)
      2'd0:    hashVec = a[47:36];
      2'd1:    hashVec = a[46:35];
      2'd2:    hashVec = a[45:34];
      default: hashVec = a[43:32];
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {rspValid,rspHit} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input string tag, input bit b, input bit c, input logic [1:0] m,
                      input bit a, input logic [47:0] ad, input bit cm,
                      input bit lk, input logic [47:0] la);
    logic [1:0] exp;
    int cntOld;
    logic [1:0] pendOld;
    cfgBegin = b; cfgClear = c; cfgMode = m; cfgAdd = a; cfgAddr = ad;
    cfgCommit = cm; lkValid = lk; lkAddr = la;
    exp = {lk, lk & mEn & la[0] & mTbl[hashVec(la, mAct)]};
    cntOld = mCnt; pendOld = mPend;
    @(posedge clk);
    if (b) begin
      mCnt = 0; mPend = m;
      if (c) mTbl = '0;
    end
    if (a) begin
      mTbl[hashVec(ad, b ? m : pendOld)] = 1'b1;
      mCnt++;
    end
    if (cm && cntOld > 0) begin
      mEn = 1'b1; mAct = pendOld;
    end
    @(negedge clk);
    check(tag, {rspValid, rspHit}, exp);
  endtask

  task automatic look(input string tag, input logic [47:0] la);
    step(tag, 0, 0, 0, 0, '0, 0, 1, la);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [47:0] addrA, addrB, addrC;
    logic [47:0] pool [8];
    int pIdx;
    void'($urandom(32'h5EED_1234));
    mTbl = '0; mEn = 0; mAct = 0; mPend = 0; mCnt = 0;
    cfgBegin = 0; cfgClear = 0; cfgMode = 0; cfgAdd = 0; cfgAddr = '0;
    cfgCommit = 0; lkValid = 0; lkAddr = '0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    addrA = 48'hA5C3_0000_0001;
    addrB = 48'h1234_0000_0001;
    addrC = 48'hF00F_0000_0001;

    // R10: reset state, everything misses
    look("R10 reset miss", addrA);
    step("R10 idle", 0, 0, 0, 0, '0, 0, 0, '0);

    // R6: empty update leaves filter off; add without enable still misses
    step("R6 begin", 1, 1, 2, 0, '0, 0, 0, '0);
    step("R6 empty commit", 0, 0, 0, 0, '0, 1, 1, addrA);
    step("R6 add", 0, 0, 0, 1, addrA, 0, 0, '0);
    look("R6 off miss", addrA);
    step("R5 commit", 0, 0, 0, 0, '0, 1, 0, '0);
    look("R5 hit after commit", addrA);
    look("R7 group bit clear", addrA & ~48'h1);
    look("R2 other vector miss", addrB);

    // R1: each window, lookups with single top bits flipped
    for (int m = 0; m < 4; m++) begin
      step("R1 begin", 1, 1, 2'(m), 1, addrC, 0, 0, '0);
      step("R1 commit", 0, 0, 0, 0, '0, 1, 0, '0);
      for (int k = 32; k < 48; k++) look("R1 window", addrC ^ (48'h1 << k));
      look("R1 exact", addrC);
    end

    // R3: accumulate without clear
    step("R3 begin", 1, 0, 0, 1, addrA, 0, 0, '0);
    step("R3 add", 0, 0, 0, 1, addrB, 1, 0, '0);
    look("R3 first kept", addrA);
    look("R3 second", addrB);
    look("R3 old kept", addrC);

    // R4: begin without clear keeps table; with clear empties it
    step("R4 keep", 1, 0, 0, 0, '0, 0, 0, '0);
    step("R4 keep commit", 0, 0, 0, 0, '0, 1, 0, '0);
    look("R4 kept hit", addrB);
    step("R4 clear", 1, 1, 0, 0, '0, 0, 0, '0);
    step("R4 clear commit", 0, 0, 0, 0, '0, 1, 0, '0);
    look("R4 cleared A", addrA);
    look("R4 cleared B", addrB);

    // R9: same-cycle add/lookup and commit/lookup
    step("R9 add+look", 0, 0, 0, 1, addrB, 0, 1, addrB);
    look("R9 next cycle", addrB);
    step("R9 begin m3", 1, 0, 3, 1, addrC, 0, 0, '0);
    step("R9 commit+look", 0, 0, 0, 0, '0, 1, 1, addrC);
    look("R9 after commit", addrC);

    // R11: add in begin cycle uses new window, after clear
    step("R11 begin+add", 1, 1, 1, 1, addrA, 0, 0, '0);
    step("R11 commit", 0, 0, 0, 0, '0, 1, 0, '0);
    look("R11 hit", addrA);
    look("R11 cleared", addrC);

    // R7 random mix
    for (int i = 0; i < 8; i++) pool[i] = {$urandom, $urandom} | 48'h1;
    pIdx = 0;
    for (int i = 0; i < 3000; i++) begin
      bit b, c, a, cm, lk;
      logic [47:0] ad, la;
      b  = ($urandom % 40) == 0;
      c  = ($urandom % 2) == 0;
      a  = ($urandom % 4) == 0;
      cm = ($urandom % 20) == 0;
      lk = ($urandom % 3) != 0;
      ad = pool[$urandom % 8];
      if (a && ($urandom % 3) == 0) begin
        ad = {$urandom, $urandom};
        pool[pIdx] = ad; pIdx = (pIdx + 1) % 8;
      end
      la = pool[$urandom % 8];
      if (($urandom % 4) == 0) la = la ^ (48'h1 << ($urandom % 48));
      step("R7 random", b, c, 2'($urandom % 4), a, ad, cm, lk, la);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule